// File: doc/BRIEF.md
# Panel Command and Status Interpreter

This block is the command layer of a small serial LCD panel controller. A byte-level transfer port sits in front of it. Each one-cycle strobe delivers one 8-bit word from the host, and the same transfer returns one 8-bit response byte. The block does three jobs:

- It decodes opcodes and gathers any parameter bytes that follow them.
- It holds the panel mode state: sleep, booster, partial/normal/scroll display mode, inversion, display enable, tearing output and a gamma curve index. It also holds a self-diagnosis byte.
- It assembles the bytes that identification and status read commands send back.

The response for a transfer is taken from a four-entry response buffer before the incoming word is decoded. A read command's reply therefore comes out on the transfers that follow it. The host normally sends the read opcode and then clocks dummy words to collect the reply. An opcode the block does not support is reported on an error output and has no other effect.

Top module: `lcd_cmd_engine`

## Requirements
- R1: After a synchronous reset (`rst` high), the mode flags are as follows:
  - sleep=1, booster=0, tearing=0, partial=0, normal=1, scroll=0, invert=0, display-on=1, gamma=0;
  - the self-diagnosis byte is 0xB0;
  - the response buffer holds zeros and its pointer is 0;
  - `xfer_rdata` and `cmd_err` are 0.
- R2: Each transfer returns the buffer entry at the pointer and then advances the pointer. After the fourth entry every transfer returns 0x00. `xfer_rdata` is registered: it changes in the cycle after the strobe and holds between strobes.
- R3: A read opcode still returns the byte selected before it is decoded. It then reloads all four buffer entries, with unused entries set to 0x00, and sets the pointer to 0.
- R4: The panel ID is 0x838F03. Opcode 0x04 returns 0x83, 0x8F, 0x03. Opcodes 0xDA, 0xDB and 0xDC each return one byte: 0x83, 0x8F and 0x03 respectively.
- R5: Opcode 0x09 returns four status bytes:
  - byte 0 is {booster,7'b0};
  - byte 1 is 0x50 | partial<<2 | sleep<<1 | normal;
  - byte 2 is scroll<<7 | invert<<5 | display-on<<2 | tearing<<1 | gamma[2];
  - byte 3 is gamma[1:0]<<6.
- R6: The single-byte reads return these values:
  - opcode 0x0A: booster<<7 | sleep<<6 | partial<<5 | sleep<<4 | normal<<3 | display-on<<2;
  - opcode 0x0C: 0x05;
  - opcode 0x0D: scroll<<7 | invert<<5 | gamma;
  - opcode 0x0E: tearing<<7;
  - opcode 0x0F: the self-diagnosis byte.
- R7: The mode opcodes act as follows:
  - 0x12 sets partial=1, normal=0, scroll=0;
  - 0x13 sets normal=1, partial=0, scroll=0;
  - 0x37 sets scroll=1, partial=0, normal=0;
  - 0x20 and 0x21 clear and set invert;
  - 0x28 and 0x29 clear and set display-on;
  - 0x02 and 0x03 clear and set booster;
  - 0x34 clears tearing.
- R8: Opcode 0x10 sets sleep. Opcode 0x11 clears sleep and toggles bit 6 of the self-diagnosis byte.
- R9: Opcodes 0x26 and 0x35 take one parameter word; opcodes 0xB0, 0xB1 and 0xC2 take two. Parameter words are never decoded as opcodes and never raise `cmd_err`.
- R10: On the parameter of 0x26, gamma becomes the index of the lowest set bit among parameter bits [3:0]. If none of those bits is set, gamma is unchanged. Tearing becomes 1 only when the parameter of 0x35 arrives.
- R11: An opcode outside the supported set (0x00–0x04, 0x09–0x13, 0x20, 0x21, 0x26, 0x28, 0x29, 0x34, 0x35, 0x37, 0xB0, 0xB1, 0xC2, 0xDA–0xDC, excluding 0x05–0x08 and 0x0B) drives `cmd_err` high for exactly the cycle after its strobe. It changes no mode flag and does not reload the buffer.
- R12: Opcode 0x01 restores the R1 flag values and the self-diagnosis byte, and clears the pending parameter count and the current command. It leaves the response buffer and its pointer untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_valid | input | 1 | One-cycle strobe: a word is transferred in this cycle |
| xfer_wdata | input | 8 | Word from the host (opcode or parameter) |
| xfer_rdata | output | 8 | Response byte of the last transfer, valid the cycle after the strobe |
| cmd_err | output | 1 | Pulses for one cycle when an unsupported opcode was received |

## Verification
A wrong mode flag does not show at the ports until a status or mode read is issued. It then appears in a specific bit of the byte returned one to four transfers after the read opcode, so the bench reads back after every group of mode changes.

A wrong pending count shows immediately: a parameter is decoded as an opcode, or an opcode is swallowed. The effect is a missing or spurious `cmd_err` pulse, or a later read that disagrees.

A wrong buffer pointer shifts every reply byte by one transfer. It is caught on the first multi-byte read after the fault.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

    localparam int BYTE_W     = 8;
    localparam int RESP_DEPTH = 4;
    localparam int PTR_W      = $clog2(RESP_DEPTH + 1);
    localparam int IDX_W      = $clog2(RESP_DEPTH);
    localparam int PEND_W     = 2;
    localparam int GAMMA_W    = 3;
    localparam logic [23:0]       PANEL_ID   = 24'h838F03;
    localparam logic [BYTE_W-1:0] DIAG_RESET = 8'hB0;
    localparam logic [BYTE_W-1:0] PIXFMT_VAL = 8'h05;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [RESP_DEPTH-1:0][BYTE_W-1:0] resp_t;

    typedef struct packed {
        logic               sleep;
        logic               booster;
        logic               te;
        logic               partial;
        logic               normal;
        logic               scroll;
        logic               invert;
        logic               disp_on;
        logic [GAMMA_W-1:0] gamma;
    } mode_t;

    typedef enum logic [3:0] {
        A_NONE, A_SWRST, A_BOOST_OFF, A_BOOST_ON, A_SLEEP_IN, A_SLEEP_OUT,
        A_PARTIAL, A_NORMAL, A_SCROLL, A_INV_OFF, A_INV_ON, A_DISP_OFF,
        A_DISP_ON, A_TE_OFF, A_TE_ON, A_GAMMA
    } act_e;

    typedef enum logic [3:0] {
        RD_NONE, RD_ID, RD_ID_HI, RD_ID_MID, RD_ID_LO, RD_STATUS,
        RD_PWR, RD_PIXFMT, RD_IMAGE, RD_SIGNAL, RD_DIAG
    } rd_e;

    typedef struct packed {
        act_e              act;
        rd_e               rd;
        logic [PEND_W-1:0] nparam;
        logic              bad;
    } dec_t;

    function automatic mode_t mode_reset();
        mode_t m;
        m = '0;
        m.sleep   = 1'b1;
        m.normal  = 1'b1;
        m.disp_on = 1'b1;
        return m;
    endfunction

    // Decode a word received while no parameter is pending.
    function automatic dec_t decode_op(byte_t op);
        dec_t d;
        d = '{act: A_NONE, rd: RD_NONE, nparam: '0, bad: 1'b0};
        case (op)
            8'h00: ;
            8'h01: d.act = A_SWRST;
            8'h02: d.act = A_BOOST_OFF;
            8'h03: d.act = A_BOOST_ON;
            8'h04: d.rd  = RD_ID;
            8'h09: d.rd  = RD_STATUS;
            8'h0A: d.rd  = RD_PWR;
            8'h0C: d.rd  = RD_PIXFMT;
            8'h0D: d.rd  = RD_IMAGE;
            8'h0E: d.rd  = RD_SIGNAL;
            8'h0F: d.rd  = RD_DIAG;
            8'h10: d.act = A_SLEEP_IN;
            8'h11: d.act = A_SLEEP_OUT;
            8'h12: d.act = A_PARTIAL;
            8'h13: d.act = A_NORMAL;
            8'h20: d.act = A_INV_OFF;
            8'h21: d.act = A_INV_ON;
            8'h26: d.nparam = PEND_W'(1);
            8'h28: d.act = A_DISP_OFF;
            8'h29: d.act = A_DISP_ON;
            8'h34: d.act = A_TE_OFF;
            8'h35: d.nparam = PEND_W'(1);
            8'h37: d.act = A_SCROLL;
            8'hB0, 8'hB1, 8'hC2: d.nparam = PEND_W'(2);
            8'hDA: d.rd  = RD_ID_HI;
            8'hDB: d.rd  = RD_ID_MID;
            8'hDC: d.rd  = RD_ID_LO;
            default: d.bad = 1'b1;
        endcase
        return d;
    endfunction

    function automatic resp_t build_resp(rd_e rd, mode_t m, byte_t diag);
        resp_t r;
        r = '0;
        case (rd)
            RD_ID: begin
                r[0] = PANEL_ID[23:16];
                r[1] = PANEL_ID[15:8];
                r[2] = PANEL_ID[7:0];
            end
            RD_ID_HI:  r[0] = PANEL_ID[23:16];
            RD_ID_MID: r[0] = PANEL_ID[15:8];
            RD_ID_LO:  r[0] = PANEL_ID[7:0];
            RD_STATUS: begin
                r[0] = {m.booster, 7'b0};
                r[1] = {4'b0101, 1'b0, m.partial, m.sleep, m.normal};
                r[2] = {m.scroll, 1'b0, m.invert, 2'b00, m.disp_on, m.te, m.gamma[2]};
                r[3] = {m.gamma[1:0], 6'b0};
            end
            RD_PWR:    r[0] = {m.booster, m.sleep, m.partial, m.sleep,
                               m.normal, m.disp_on, 2'b00};
            RD_PIXFMT: r[0] = PIXFMT_VAL;
            RD_IMAGE:  r[0] = {m.scroll, 1'b0, m.invert, 2'b00, m.gamma};
            RD_SIGNAL: r[0] = {m.te, 7'b0};
            RD_DIAG:   r[0] = diag;
            default:   r = '0;
        endcase
        return r;
    endfunction

    // Index of the lowest set bit of a nibble (caller checks nibble != 0).
    function automatic logic [GAMMA_W-1:0] low_bit_idx(logic [3:0] n);
        logic [GAMMA_W-1:0] idx;
        idx = '0;
        for (int i = 3; i >= 0; i--) begin
            if (n[i]) idx = GAMMA_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/lcd_cmd_seq.sv
module lcd_cmd_seq
    import lcd_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  byte_t             wdata,
    output act_e              act,
    output rd_e               rd,
    output logic              bad,
    output logic [PEND_W-1:0] pend
);
    logic [PEND_W-1:0] pend_q;
    byte_t             cur_q;
    dec_t              dec;
    logic              is_param;

    assign is_param = (pend_q != '0);

    always_comb begin
        dec = decode_op(wdata);
        act = A_NONE;
        rd  = RD_NONE;
        bad = 1'b0;
        if (valid) begin
            if (is_param) begin
                // Final parameter completes the command held in cur_q.
                if (pend_q == PEND_W'(1)) begin
                    if (cur_q == 8'h26)      act = A_GAMMA;
                    else if (cur_q == 8'h35) act = A_TE_ON;
                end
            end else begin
                act = dec.act;
                rd  = dec.rd;
                bad = dec.bad;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            cur_q  <= '0;
        end else if (valid) begin
            if (is_param) begin
                pend_q <= pend_q - PEND_W'(1);
            end else if (dec.act == A_SWRST) begin
                pend_q <= '0;
                cur_q  <= '0;
            end else begin
                pend_q <= dec.nparam;
                cur_q  <= wdata;
            end
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/lcd_mode_regs.sv
module lcd_mode_regs
    import lcd_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  act_e       act,
    input  logic [3:0] param_lo,
    output mode_t      mode,
    output byte_t      diag
);
    mode_t mode_q;
    byte_t diag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= mode_reset();
            diag_q <= DIAG_RESET;
        end else begin
            case (act)
                A_SWRST: begin
                    mode_q <= mode_reset();
                    diag_q <= DIAG_RESET;
                end
                A_BOOST_OFF: mode_q.booster <= 1'b0;
                A_BOOST_ON:  mode_q.booster <= 1'b1;
                A_SLEEP_IN:  mode_q.sleep   <= 1'b1;
                A_SLEEP_OUT: begin
                    mode_q.sleep <= 1'b0;
                    diag_q[6]    <= ~diag_q[6];
                end
                A_PARTIAL: begin
                    mode_q.partial <= 1'b1;
                    mode_q.normal  <= 1'b0;
                    mode_q.scroll  <= 1'b0;
                end
                A_NORMAL: begin
                    mode_q.partial <= 1'b0;
                    mode_q.normal  <= 1'b1;
                    mode_q.scroll  <= 1'b0;
                end
                A_SCROLL: begin
                    mode_q.partial <= 1'b0;
                    mode_q.normal  <= 1'b0;
                    mode_q.scroll  <= 1'b1;
                end
                A_INV_OFF:  mode_q.invert  <= 1'b0;
                A_INV_ON:   mode_q.invert  <= 1'b1;
                A_DISP_OFF: mode_q.disp_on <= 1'b0;
                A_DISP_ON:  mode_q.disp_on <= 1'b1;
                A_TE_OFF:   mode_q.te      <= 1'b0;
                A_TE_ON:    mode_q.te      <= 1'b1;
                A_GAMMA: if (param_lo != 4'h0) mode_q.gamma <= low_bit_idx(param_lo);
                default: ;
            endcase
        end
    end

    assign mode = mode_q;
    assign diag = diag_q;
endmodule

// File: rtl/lcd_resp_buf.sv
module lcd_resp_buf
    import lcd_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  rd_e              rd,
    input  logic             bad,
    input  mode_t            mode,
    input  byte_t            diag,
    output byte_t            rdata,
    output logic             err,
    output logic [PTR_W-1:0] ptr
);
    resp_t            buf_q;
    logic [PTR_W-1:0] ptr_q;
    byte_t            rdata_q;
    logic             err_q;
    logic             in_range;

    assign in_range = (ptr_q < PTR_W'(RESP_DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q   <= '0;
            ptr_q   <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= valid & bad;
            if (valid) begin
                // Reply byte is picked from the state before this word is decoded.
                rdata_q <= in_range ? buf_q[ptr_q[IDX_W-1:0]] : '0;
                if (rd != RD_NONE) begin
                    buf_q <= build_resp(rd, mode, diag);
                    ptr_q <= '0;
                end else if (in_range) begin
                    ptr_q <= ptr_q + PTR_W'(1);
                end
            end
        end
    end

    assign rdata = rdata_q;
    assign err   = err_q;
    assign ptr   = ptr_q;
endmodule

// File: rtl/lcd_cmd_engine.sv
module lcd_cmd_engine
    import lcd_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       xfer_valid,
    input  logic [7:0] xfer_wdata,
    output logic [7:0] xfer_rdata,
    output logic       cmd_err
);
    act_e              act;
    rd_e               rd;
    logic              bad;
    logic [PEND_W-1:0] pend_q;
    mode_t             mode_q;
    byte_t             diag_q;
    logic [PTR_W-1:0]  rsp_ptr;

    lcd_cmd_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .valid (xfer_valid),
        .wdata (xfer_wdata),
        .act   (act),
        .rd    (rd),
        .bad   (bad),
        .pend  (pend_q)
    );

    lcd_mode_regs u_mode (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .param_lo (xfer_wdata[3:0]),
        .mode     (mode_q),
        .diag     (diag_q)
    );

    lcd_resp_buf u_resp (
        .clk   (clk),
        .rst   (rst),
        .valid (xfer_valid),
        .rd    (rd),
        .bad   (bad),
        .mode  (mode_q),
        .diag  (diag_q),
        .rdata (xfer_rdata),
        .err   (cmd_err),
        .ptr   (rsp_ptr)
    );
endmodule

module lcd_cmd_engine_chk
    import lcd_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              xfer_valid,
    input logic [7:0]        xfer_wdata,
    input logic [7:0]        xfer_rdata,
    input logic              cmd_err,
    input mode_t             mode,
    input logic [PEND_W-1:0] pend,
    input logic [PTR_W-1:0]  ptr
);
    // R11
    err_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> $past(xfer_valid));
    // R11
    err_keeps_mode_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> (mode == $past(mode)));
    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(xfer_valid) |-> $stable(xfer_rdata));
    // R2
    ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ptr <= PTR_W'(RESP_DEPTH));
    // R9
    pend_count_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(xfer_valid) && ($past(pend) != '0)) |-> (pend == $past(pend) - PEND_W'(1)));
    // R7
    one_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mode.partial, mode.normal, mode.scroll}));
    // R8
    sleep_out_chk: assert property (@(posedge clk) disable iff (rst)
        $past(xfer_valid && (pend == '0) && (xfer_wdata == 8'h11)) |-> !mode.sleep);
endmodule

bind lcd_cmd_engine lcd_cmd_engine_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .xfer_valid (xfer_valid),
    .xfer_wdata (xfer_wdata),
    .xfer_rdata (xfer_rdata),
    .cmd_err    (cmd_err),
    .mode       (mode_q),
    .pend       (pend_q),
    .ptr        (rsp_ptr)
);

// File: tb/lcd_cmd_engine_tb.sv
module lcd_cmd_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xfer_valid = 1'b0;
    logic [7:0] xfer_wdata = 8'h00;
    logic [7:0] xfer_rdata;
    logic       cmd_err;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 1'b0;
    bit  strobe_seen = 1'b0;

    logic [7:0] exp_r_q[$];
    bit         exp_e_q[$];
    string      exp_t_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_cmd_engine u_dut (
        .clk        (clk),
        .rst        (rst),
        .xfer_valid (xfer_valid),
        .xfer_wdata (xfer_wdata),
        .xfer_rdata (xfer_rdata),
        .cmd_err    (cmd_err)
    );

    always @(posedge clk) strobe_seen <= xfer_valid;

    // Driver: one strobe per call, expected reply and error pushed to the scoreboard.
    task automatic xfer(input logic [7:0] w, input logic [7:0] er, input bit ee, input string tag);
        @(negedge clk);
        xfer_valid = 1'b1;
        xfer_wdata = w;
        exp_r_q.push_back(er);
        exp_e_q.push_back(ee);
        exp_t_q.push_back(tag);
        @(negedge clk);
        xfer_valid = 1'b0;
    endtask

    // Monitor: compare outputs in the cycle after each strobe.
    initial begin
        forever begin
            @(negedge clk);
            if (strobe_seen && !rst) begin
                if (exp_r_q.size() == 0) begin
                    failures++;
                    $display("FAIL R2: unexpected transfer result actual=%02h expected=none", xfer_rdata);
                end else begin
                    logic [7:0] er;
                    bit ee;
                    string t;
                    er = exp_r_q.pop_front();
                    ee = exp_e_q.pop_front();
                    t  = exp_t_q.pop_front();
                    checks++;
                    if (xfer_rdata !== er) begin
                        failures++;
                        $display("FAIL %s: rdata actual=%02h expected=%02h", t, xfer_rdata, er);
                    end
                    checks++;
                    if (cmd_err !== ee) begin
                        failures++;
                        $display("FAIL %s: cmd_err actual=%0b expected=%0b", t, cmd_err, ee);
                    end
                end
            end
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not end actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        checks++;
        if (xfer_rdata !== 8'h00 || cmd_err !== 1'b0) begin
            failures++;
            $display("FAIL R1: reset outputs actual=%02h/%0b expected=00/0", xfer_rdata, cmd_err);
        end

        // R1 / R5: status after reset
        xfer(8'h09, 8'h00, 0, "R1");
        xfer(8'h00, 8'h00, 0, "R5");
        xfer(8'h00, 8'h53, 0, "R1");
        xfer(8'h00, 8'h04, 0, "R5");
        xfer(8'h00, 8'h00, 0, "R5");
        xfer(8'h00, 8'h00, 0, "R2");   // past the fourth entry
        // R6 / R8: power-mode read, sleep out, diagnosis byte
        xfer(8'h0A, 8'h00, 0, "R2");
        xfer(8'h11, 8'h5C, 0, "R6");
        xfer(8'h0F, 8'h00, 0, "R8");
        xfer(8'h0A, 8'hF0, 0, "R8");
        xfer(8'h00, 8'h0C, 0, "R8");
        // R3 / R4: ID reads, old byte returned on the read opcode itself
        xfer(8'h04, 8'h00, 0, "R3");
        xfer(8'hDB, 8'h83, 0, "R4");
        xfer(8'hDC, 8'h8F, 0, "R4");
        xfer(8'hDA, 8'h03, 0, "R4");
        xfer(8'h00, 8'h83, 0, "R4");
        // R7: partial, invert on, booster on, display off
        xfer(8'h12, 8'h00, 0, "R7");
        xfer(8'h21, 8'h00, 0, "R7");
        xfer(8'h03, 8'h00, 0, "R7");
        xfer(8'h28, 8'h00, 0, "R7");
        xfer(8'h09, 8'h00, 0, "R7");
        xfer(8'h00, 8'h80, 0, "R7");
        xfer(8'h00, 8'h54, 0, "R7");
        xfer(8'h00, 8'h20, 0, "R7");
        xfer(8'h00, 8'h00, 0, "R5");
        // R10: gamma parameter 0x08 -> 3, tearing via 0x35 parameter
        xfer(8'h26, 8'h00, 0, "R9");
        xfer(8'h08, 8'h00, 0, "R10");
        xfer(8'h35, 8'h00, 0, "R9");
        xfer(8'h01, 8'h00, 0, "R9");   // parameter, not a reset
        xfer(8'h0D, 8'h00, 0, "R10");
        xfer(8'h0E, 8'h23, 0, "R10");
        xfer(8'h09, 8'h80, 0, "R10");
        xfer(8'h00, 8'h80, 0, "R5");
        xfer(8'h00, 8'h54, 0, "R5");
        xfer(8'h00, 8'h22, 0, "R10");
        xfer(8'h00, 8'hC0, 0, "R10");
        // R10: zero nibble leaves gamma
        xfer(8'h26, 8'h00, 0, "R10");
        xfer(8'h00, 8'h00, 0, "R10");
        xfer(8'h0D, 8'h00, 0, "R10");
        xfer(8'h00, 8'h23, 0, "R10");
        // R9: two parameters absorbed, sleep stays out
        xfer(8'hB0, 8'h00, 0, "R9");
        xfer(8'h01, 8'h00, 0, "R9");
        xfer(8'h01, 8'h00, 0, "R9");
        xfer(8'h0A, 8'h00, 0, "R9");
        xfer(8'h00, 8'hA0, 0, "R9");
        // R7: scroll then normal
        xfer(8'h37, 8'h00, 0, "R7");
        xfer(8'h0D, 8'h00, 0, "R7");
        xfer(8'h00, 8'hA3, 0, "R7");
        xfer(8'h13, 8'h00, 0, "R7");
        xfer(8'h09, 8'h00, 0, "R7");
        xfer(8'h00, 8'h80, 0, "R7");
        xfer(8'h00, 8'h51, 0, "R7");
        // R11: unsupported opcodes flag an error, buffer keeps popping
        xfer(8'h2A, 8'h22, 1, "R11");
        xfer(8'h36, 8'hC0, 1, "R11");
        xfer(8'h0C, 8'h00, 0, "R6");
        xfer(8'h00, 8'h05, 0, "R6");
        xfer(8'h00, 8'h00, 0, "R3");   // unused entry zero-filled
        // R7 / R8: clear flags, sleep in
        xfer(8'h20, 8'h00, 0, "R7");
        xfer(8'h29, 8'h00, 0, "R7");
        xfer(8'h02, 8'h00, 0, "R7");
        xfer(8'h34, 8'h00, 0, "R7");
        xfer(8'h10, 8'h00, 0, "R8");
        xfer(8'h09, 8'h00, 0, "R8");
        xfer(8'h00, 8'h00, 0, "R7");
        xfer(8'h00, 8'h53, 0, "R8");
        xfer(8'h00, 8'h04, 0, "R7");
        xfer(8'h00, 8'hC0, 0, "R11");  // gamma untouched by errors
        // R12: software reset
        xfer(8'h21, 8'h00, 0, "R12");
        xfer(8'h01, 8'h00, 0, "R12");
        xfer(8'h09, 8'h00, 0, "R12");
        xfer(8'h00, 8'h00, 0, "R12");
        xfer(8'h00, 8'h53, 0, "R12");
        xfer(8'h00, 8'h04, 0, "R12");
        xfer(8'h00, 8'h00, 0, "R12");
        xfer(8'h0F, 8'h00, 0, "R12");
        xfer(8'h00, 8'hB0, 0, "R12");
        // R9 / R10: unsupported code as a parameter raises no error
        xfer(8'h26, 8'h00, 0, "R9");
        xfer(8'h2A, 8'h00, 0, "R9");
        xfer(8'h0D, 8'h00, 0, "R10");
        xfer(8'h00, 8'h01, 0, "R10");

        repeat (4) @(negedge clk);
        checks++;
        if (exp_r_q.size() != 0) begin
            failures++;
            $display("FAIL R2: pending results actual=%0d expected=0", exp_r_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule